// File: doc/BRIEF.md
# Two-Stage Block-Ahead Fetch Address Generator

This block produces the start address of the fetch block two steps ahead of the one currently being looked up, for a front end that fetches one block per cycle. Prediction is spread over two pipeline stages. In the first stage the direction table is read with an index formed from the previous branch's address and the global history. In the second stage that counter value is combined with externally supplied lookup results to pick the next fetch address. The lookup results are the taken-path entry, the fall-through-path entry, the top of the return stack and the top of the call-side second stack.

Because the index uses the branch that ended the previous block, the lookup for block B can start while block A's address is still being chosen. The branch position chosen in stage 2 is fed straight back into the stage-1 index in the same cycle. That lets consecutive blocks flow through without bubbles.

On every conditional prediction the block keeps the address of the path it did not choose, together with the matching history. A later redirect can then start from those without an extra cycle. The direction table holds 2-bit saturating counters that are trained by a resolution port. The global history shifts speculatively and can be overwritten by a redirect.

Top module: `fetch_ahead_gen`

## Requirements
- R1: After reset, `ghr_o`, `alt_addr_q` and `alt_hist_q` are zero, `nxt_valid` is 0, and every counter holds weakly not-taken (value 1). A single taken update therefore makes that entry predict taken.
- R2: Transition codes are T=0, N=1 and R=2; code 3 behaves as N. Entry kind codes are conditional=0, jump=1, return=2 and indirect=3. Under T the taken-path entry (`tk_*`) is used, and under N the fall-through entry (`nt_*`) is used. A jump or indirect entry yields its target.
- R3: A conditional entry yields its target when the counter predicts taken. Otherwise it yields `{s2_line, pos} + 1`, where `pos` is the 4-bit branch position in the low bits, so the last position rolls into the next line.
- R4: A return entry yields `ras_top`.
- R5: Under T or N, a miss of the selected entry yields the fall-through address `{s2_line + 1, 0}`. In that case `nxt_pos` is all ones and `nxt_xfer` is N.
- R6: Under R, the second-stack entry (`sas_*`) is used with the same kind rules as R2 to R4. If `sas_valid` is 0, the fall-through address is used.
- R7: The table index is `{s1_line, p}[HIST_W-1:0] ^ ghr_o`. Here `p` is `nxt_pos` when stage 2 is valid in that cycle, and `s1_pos` otherwise.
- R8: Counters saturate at 0 and 3 under `upd_valid`/`upd_idx`/`upd_taken`. A counter predicts taken when its value is 2 or more.
- R9: When stage 2 makes a conditional prediction, `ghr_o` shifts the predicted outcome into bit 0. A cycle with `rd_valid` loads `rd_hist` instead, with priority over the shift.
- R10: On each conditional prediction, `alt_addr_q` takes the address that was not chosen. `alt_hist_q` takes the history shifted with the opposite outcome.
- R11: `nxt_xfer` is T for a taken conditional, a jump or an indirect entry. It is R for a return and N otherwise. `nxt_cond` and `nxt_taken` flag a conditional prediction and its outcome.
- R12: `nxt_valid` is `s1_valid` delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s1_valid | input | 1 | Stage-1 lookup request |
| s1_line | input | LINE_W | Line address used for the stage-1 index |
| s1_pos | input | POS_W | Branch position used when stage 2 is idle |
| s2_line | input | LINE_W | Line of the block whose exit is being predicted |
| s2_xfer | input | 2 | Transition into that block (T/N/R) |
| tk_hit | input | 1 | Taken-path entry hit |
| tk_kind | input | 2 | Taken-path entry kind |
| tk_tgt | input | ADDR_W | Taken-path entry target |
| tk_pos | input | POS_W | Taken-path entry branch position |
| nt_hit | input | 1 | Fall-through-path entry hit |
| nt_kind | input | 2 | Fall-through-path entry kind |
| nt_tgt | input | ADDR_W | Fall-through-path entry target |
| nt_pos | input | POS_W | Fall-through-path entry branch position |
| sas_valid | input | 1 | Second-stack top is valid |
| sas_kind | input | 2 | Second-stack entry kind |
| sas_tgt | input | ADDR_W | Second-stack entry target |
| sas_pos | input | POS_W | Second-stack entry branch position |
| ras_top | input | ADDR_W | Return-stack top |
| upd_valid | input | 1 | Counter training request |
| upd_idx | input | HIST_W | Counter to train |
| upd_taken | input | 1 | Resolved outcome |
| rd_valid | input | 1 | Redirect: load history |
| rd_hist | input | HIST_W | History to restore |
| nxt_valid | output | 1 | Stage-2 result valid |
| nxt_addr | output | ADDR_W | Chosen next fetch address |
| nxt_pos | output | POS_W | Branch position forwarded to stage 1 |
| nxt_xfer | output | 2 | Transition type of the chosen exit |
| nxt_cond | output | 1 | Prediction used a conditional counter |
| nxt_taken | output | 1 | Predicted outcome |
| ghr_o | output | HIST_W | Global history |
| alt_addr_q | output | ADDR_W | Saved non-chosen address |
| alt_hist_q | output | HIST_W | Saved history for the non-chosen path |

## Verification
The checker verifies several properties on every cycle:
- the one-cycle stage spacing;
- return and fall-through selection against the live inputs;
- the history shift and its redirect priority;
- the opposite-outcome bit in the saved history.

Other behaviours need set-up sequences that only the bench's scenarios provide. These are the counter reset value and saturation, the same-cycle forwarding of the branch position into the next index, and the choice among the five candidates for each kind and transition.

// File: rtl/fag_pkg.sv
package fag_pkg;
   typedef enum logic [1:0] {
      KIND_COND = 2'd0,
      KIND_JUMP = 2'd1,
      KIND_RET  = 2'd2,
      KIND_IND  = 2'd3
   } br_kind_e;

   typedef enum logic [1:0] {
      XF_TAKEN = 2'd0,
      XF_FALL  = 2'd1,
      XF_RET   = 2'd2,
      XF_RSVD  = 2'd3
   } xfer_e;

   localparam logic [1:0] CTR_WEAK_NT = 2'b01;
endpackage

// File: rtl/fag_ctr_table.sv
module fag_ctr_table #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIST_W-1:0] rd_idx,
   output logic              rd_taken,
   input  logic              wr_en,
   input  logic [HIST_W-1:0] wr_idx,
   input  logic              wr_taken
);
   localparam int DEPTH = 1 << HIST_W;

   logic [DEPTH-1:0] taken_vec;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [1:0] ctr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctr <= fag_pkg::CTR_WEAK_NT;
         end else if (wr_en && (wr_idx == HIST_W'(i))) begin
            if (wr_taken && ctr != 2'b11)      ctr <= ctr + 2'd1;
            else if (!wr_taken && ctr != 2'b00) ctr <= ctr - 2'd1;
         end
      end
      assign taken_vec[i] = ctr[1];
   end

   assign rd_taken = taken_vec[rd_idx];
endmodule

// File: rtl/fag_select.sv
module fag_select
   import fag_pkg::*;
#(
   parameter int LINE_W = 12,
   parameter int POS_W  = 4
) (
   input  logic [LINE_W-1:0]       line,
   input  logic [1:0]              xfer_in,
   input  logic                    pred_taken,
   input  logic                    tk_hit,
   input  logic [1:0]              tk_kind,
   input  logic [LINE_W+POS_W-1:0] tk_tgt,
   input  logic [POS_W-1:0]        tk_pos,
   input  logic                    nt_hit,
   input  logic [1:0]              nt_kind,
   input  logic [LINE_W+POS_W-1:0] nt_tgt,
   input  logic [POS_W-1:0]        nt_pos,
   input  logic                    sas_valid,
   input  logic [1:0]              sas_kind,
   input  logic [LINE_W+POS_W-1:0] sas_tgt,
   input  logic [POS_W-1:0]        sas_pos,
   input  logic [LINE_W+POS_W-1:0] ras_top,
   output logic [LINE_W+POS_W-1:0] addr,
   output logic [LINE_W+POS_W-1:0] alt,
   output logic [POS_W-1:0]        pos,
   output logic [1:0]              xfer_out,
   output logic                    is_cond,
   output logic                    taken
);
   localparam int ADDR_W = LINE_W + POS_W;

   logic              e_hit;
   logic [1:0]        e_kind;
   logic [ADDR_W-1:0] e_tgt;
   logic [POS_W-1:0]  e_pos;
   logic [ADDR_W-1:0] fall_addr;
   logic [ADDR_W-1:0] seq_addr;

   always_comb begin
      unique case (xfer_e'(xfer_in))
         XF_TAKEN: begin e_hit = tk_hit;    e_kind = tk_kind;  e_tgt = tk_tgt;  e_pos = tk_pos;  end
         XF_RET:   begin e_hit = sas_valid; e_kind = sas_kind; e_tgt = sas_tgt; e_pos = sas_pos; end
         default:  begin e_hit = nt_hit;    e_kind = nt_kind;  e_tgt = nt_tgt;  e_pos = nt_pos;  end
      endcase
   end

   assign fall_addr = {line + LINE_W'(1), {POS_W{1'b0}}};
   assign seq_addr  = {line, e_pos} + ADDR_W'(1);

   always_comb begin
      addr     = fall_addr;
      alt      = fall_addr;
      pos      = {POS_W{1'b1}};
      xfer_out = XF_FALL;
      is_cond  = 1'b0;
      taken    = 1'b0;
      if (e_hit) begin
         pos = e_pos;
         unique case (br_kind_e'(e_kind))
            KIND_COND: begin
               is_cond  = 1'b1;
               taken    = pred_taken;
               addr     = pred_taken ? e_tgt : seq_addr;
               alt      = pred_taken ? seq_addr : e_tgt;
               xfer_out = pred_taken ? XF_TAKEN : XF_FALL;
            end
            KIND_RET: begin
               addr     = ras_top;
               alt      = ras_top;
               xfer_out = XF_RET;
            end
            default: begin
               addr     = e_tgt;
               alt      = e_tgt;
               xfer_out = XF_TAKEN;
            end
         endcase
      end
   end
endmodule

// File: rtl/fag_hist.sv
module fag_hist #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   input  logic              load_en,
   input  logic [HIST_W-1:0] load_val,
   output logic [HIST_W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist <= '0;
      else if (load_en)  hist <= load_val;
      else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
   end
endmodule

// File: rtl/fetch_ahead_gen.sv
module fetch_ahead_gen #(
   parameter int LINE_W = 12,
   parameter int POS_W  = 4,
   parameter int HIST_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s1_valid,
   input  logic [LINE_W-1:0]       s1_line,
   input  logic [POS_W-1:0]        s1_pos,
   input  logic [LINE_W-1:0]       s2_line,
   input  logic [1:0]              s2_xfer,
   input  logic                    tk_hit,
   input  logic [1:0]              tk_kind,
   input  logic [LINE_W+POS_W-1:0] tk_tgt,
   input  logic [POS_W-1:0]        tk_pos,
   input  logic                    nt_hit,
   input  logic [1:0]              nt_kind,
   input  logic [LINE_W+POS_W-1:0] nt_tgt,
   input  logic [POS_W-1:0]        nt_pos,
   input  logic                    sas_valid,
   input  logic [1:0]              sas_kind,
   input  logic [LINE_W+POS_W-1:0] sas_tgt,
   input  logic [POS_W-1:0]        sas_pos,
   input  logic [LINE_W+POS_W-1:0] ras_top,
   input  logic                    upd_valid,
   input  logic [HIST_W-1:0]       upd_idx,
   input  logic                    upd_taken,
   input  logic                    rd_valid,
   input  logic [HIST_W-1:0]       rd_hist,
   output logic                    nxt_valid,
   output logic [LINE_W+POS_W-1:0] nxt_addr,
   output logic [POS_W-1:0]        nxt_pos,
   output logic [1:0]              nxt_xfer,
   output logic                    nxt_cond,
   output logic                    nxt_taken,
   output logic [HIST_W-1:0]       ghr_o,
   output logic [LINE_W+POS_W-1:0] alt_addr_q,
   output logic [HIST_W-1:0]       alt_hist_q
);
   localparam int ADDR_W = LINE_W + POS_W;

   if (HIST_W < 2 || HIST_W > ADDR_W) begin : g_bad_hist
      $error("fetch_ahead_gen: HIST_W must lie in 2..LINE_W+POS_W");
   end
   if (LINE_W < 1 || POS_W < 1) begin : g_bad_geom
      $error("fetch_ahead_gen: LINE_W and POS_W must be positive");
   end

   // stage 1: index from the previous branch, position forwarded from stage 2
   logic [POS_W-1:0]  pos_sel;
   logic [ADDR_W-1:0] s1_br_addr;
   logic [HIST_W-1:0] s1_idx;
   logic              s1_pred;

   assign pos_sel    = nxt_valid ? nxt_pos : s1_pos;
   assign s1_br_addr = {s1_line, pos_sel};
   assign s1_idx     = s1_br_addr[HIST_W-1:0] ^ ghr_o;

   fag_ctr_table #(.HIST_W(HIST_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (s1_idx),
      .rd_taken (s1_pred),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken)
   );

   // stage 1 -> stage 2 registers
   logic s2_valid_q;
   logic s2_pred_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid_q <= 1'b0;
         s2_pred_q  <= 1'b0;
      end else begin
         s2_valid_q <= s1_valid;
         s2_pred_q  <= s1_pred;
      end
   end

   // stage 2: candidate selection
   logic [ADDR_W-1:0] sel_alt;
   logic              sel_cond;
   logic              sel_taken;

   fag_select #(.LINE_W(LINE_W), .POS_W(POS_W)) u_sel (
      .line       (s2_line),
      .xfer_in    (s2_xfer),
      .pred_taken (s2_pred_q),
      .tk_hit     (tk_hit),
      .tk_kind    (tk_kind),
      .tk_tgt     (tk_tgt),
      .tk_pos     (tk_pos),
      .nt_hit     (nt_hit),
      .nt_kind    (nt_kind),
      .nt_tgt     (nt_tgt),
      .nt_pos     (nt_pos),
      .sas_valid  (sas_valid),
      .sas_kind   (sas_kind),
      .sas_tgt    (sas_tgt),
      .sas_pos    (sas_pos),
      .ras_top    (ras_top),
      .addr       (nxt_addr),
      .alt        (sel_alt),
      .pos        (nxt_pos),
      .xfer_out   (nxt_xfer),
      .is_cond    (sel_cond),
      .taken      (sel_taken)
   );

   assign nxt_valid = s2_valid_q;
   assign nxt_cond  = sel_cond;
   assign nxt_taken = sel_taken;

   logic cond_fire;
   assign cond_fire = s2_valid_q & sel_cond;

   fag_hist #(.HIST_W(HIST_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (cond_fire),
      .shift_bit (sel_taken),
      .load_en   (rd_valid),
      .load_val  (rd_hist),
      .hist      (ghr_o)
   );

   // recovery state for the path not taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alt_addr_q <= '0;
         alt_hist_q <= '0;
      end else if (cond_fire) begin
         alt_addr_q <= sel_alt;
         alt_hist_q <= {ghr_o[HIST_W-2:0], ~sel_taken};
      end
   end
endmodule

// File: rtl/fag_checker.sv
module fag_checker #(
   parameter int LINE_W = 12,
   parameter int POS_W  = 4,
   parameter int HIST_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    s1_valid,
   input logic [LINE_W-1:0]       s2_line,
   input logic [1:0]              s2_xfer,
   input logic                    tk_hit,
   input logic                    nt_hit,
   input logic [LINE_W+POS_W-1:0] ras_top,
   input logic                    rd_valid,
   input logic [HIST_W-1:0]       rd_hist,
   input logic                    nxt_valid,
   input logic [LINE_W+POS_W-1:0] nxt_addr,
   input logic [1:0]              nxt_xfer,
   input logic                    nxt_cond,
   input logic                    nxt_taken,
   input logic [HIST_W-1:0]       ghr_o,
   input logic [HIST_W-1:0]       alt_hist_q
);
   logic sel_miss;
   assign sel_miss = (s2_xfer != 2'd2) && !((s2_xfer == 2'd0) ? tk_hit : nt_hit);

   // R12
   stage_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> nxt_valid == $past(s1_valid));

   // R4
   ret_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_valid && nxt_xfer == 2'd2) |-> nxt_addr == ras_top);

   // R5
   miss_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_valid && sel_miss) |-> (nxt_addr == {s2_line + LINE_W'(1), {POS_W{1'b0}}} && nxt_xfer == 2'd1));

   // R9
   hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(rd_valid) |-> ghr_o == $past(rd_hist));

   // R9
   hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(nxt_valid && nxt_cond && !rd_valid)
      |-> ghr_o == {$past(ghr_o[HIST_W-2:0]), $past(nxt_taken)});

   // R10
   alt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(nxt_valid && nxt_cond) |-> alt_hist_q[0] == !$past(nxt_taken));
endmodule

bind fetch_ahead_gen fag_checker #(.LINE_W(LINE_W), .POS_W(POS_W), .HIST_W(HIST_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s1_valid   (s1_valid),
   .s2_line    (s2_line),
   .s2_xfer    (s2_xfer),
   .tk_hit     (tk_hit),
   .nt_hit     (nt_hit),
   .ras_top    (ras_top),
   .rd_valid   (rd_valid),
   .rd_hist    (rd_hist),
   .nxt_valid  (nxt_valid),
   .nxt_addr   (nxt_addr),
   .nxt_xfer   (nxt_xfer),
   .nxt_cond   (nxt_cond),
   .nxt_taken  (nxt_taken),
   .ghr_o      (ghr_o),
   .alt_hist_q (alt_hist_q)
);

// File: tb/fetch_ahead_gen_bench.sv
module fetch_ahead_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s1_valid = 0;
   logic [11:0] s1_line = 0;
   logic [3:0]  s1_pos = 0;
   logic [11:0] s2_line = 0;
   logic [1:0]  s2_xfer = 0;
   logic        tk_hit = 0, nt_hit = 0, sas_valid = 0;
   logic [1:0]  tk_kind = 0, nt_kind = 0, sas_kind = 0;
   logic [15:0] tk_tgt = 0, nt_tgt = 0, sas_tgt = 0, ras_top = 16'h7A30;
   logic [3:0]  tk_pos = 0, nt_pos = 0, sas_pos = 0;
   logic        upd_valid = 0, upd_taken = 0, rd_valid = 0;
   logic [7:0]  upd_idx = 0, rd_hist = 0;
   logic        nxt_valid, nxt_cond, nxt_taken;
   logic [15:0] nxt_addr, alt_addr_q;
   logic [3:0]  nxt_pos;
   logic [1:0]  nxt_xfer;
   logic [7:0]  ghr_o, alt_hist_q;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fetch_ahead_gen u_fetch_ahead_gen (.*);

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]  xf;
      logic        th; logic [1:0] tk; logic [15:0] tt; logic [3:0] tp;
      logic        nh; logic [1:0] nk; logic [15:0] nt; logic [3:0] np;
      logic        sv; logic [1:0] sk; logic [15:0] st; logic [3:0] sp;
      logic [15:0] ea; logic [3:0] ep; logic [1:0] ex;
   } vec_t;

   localparam int NV = 10;
   // all on line 0x050, counters untrained (predict not-taken), ras_top 0x7A30
   localparam vec_t VECS [NV] = '{
      // R2 T jump
      '{2'd0, 1'b1,2'd1,16'h1230,4'd5, 1'b0,2'd0,16'h0,4'd0,    1'b0,2'd0,16'h0,4'd0, 16'h1230,4'd5,2'd0},
      // R2 N uses fall-through entry
      '{2'd1, 1'b1,2'd1,16'h9990,4'd1, 1'b1,2'd1,16'h2340,4'd6, 1'b0,2'd0,16'h0,4'd0, 16'h2340,4'd6,2'd0},
      // R3 cond not-taken
      '{2'd0, 1'b1,2'd0,16'h3000,4'd7, 1'b0,2'd0,16'h0,4'd0,    1'b0,2'd0,16'h0,4'd0, 16'h0508,4'd7,2'd1},
      // R4 return
      '{2'd0, 1'b1,2'd2,16'h1111,4'd2, 1'b0,2'd0,16'h0,4'd0,    1'b0,2'd0,16'h0,4'd0, 16'h7A30,4'd2,2'd2},
      // R5 miss under N
      '{2'd1, 1'b1,2'd1,16'h8880,4'd3, 1'b0,2'd1,16'h2340,4'd6, 1'b0,2'd0,16'h0,4'd0, 16'h0510,4'hF,2'd1},
      // R6 second stack jump
      '{2'd2, 1'b1,2'd1,16'h8880,4'd3, 1'b1,2'd1,16'h2340,4'd6, 1'b1,2'd1,16'h4440,4'd9, 16'h4440,4'd9,2'd0},
      // R6 second stack invalid
      '{2'd2, 1'b1,2'd1,16'h8880,4'd3, 1'b1,2'd1,16'h2340,4'd6, 1'b0,2'd1,16'h4440,4'd9, 16'h0510,4'hF,2'd1},
      // R6 second stack return
      '{2'd2, 1'b0,2'd0,16'h0,4'd0,    1'b0,2'd0,16'h0,4'd0,    1'b1,2'd2,16'h4440,4'd1, 16'h7A30,4'd1,2'd2},
      // R2 indirect
      '{2'd0, 1'b1,2'd3,16'h5550,4'd4, 1'b0,2'd0,16'h0,4'd0,    1'b0,2'd0,16'h0,4'd0, 16'h5550,4'd4,2'd0},
      // R3 cond last position rolls to next line
      '{2'd1, 1'b0,2'd0,16'h0,4'd0,    1'b1,2'd0,16'h6000,4'hF, 1'b0,2'd0,16'h0,4'd0, 16'h0510,4'hF,2'd1}
   };

   task automatic load_vec(vec_t v, logic [11:0] line);
      s2_line = line; s2_xfer = v.xf;
      tk_hit = v.th; tk_kind = v.tk; tk_tgt = v.tt; tk_pos = v.tp;
      nt_hit = v.nh; nt_kind = v.nk; nt_tgt = v.nt; nt_pos = v.np;
      sas_valid = v.sv; sas_kind = v.sk; sas_tgt = v.st; sas_pos = v.sp;
   endtask

   task automatic train(logic [7:0] idx, logic tk);
      @(negedge clk);
      upd_valid = 1; upd_idx = idx; upd_taken = tk;
      @(negedge clk);
      upd_valid = 0;
   endtask

   // one stage-1 lookup, then stage-2 with a taken-path conditional entry
   task automatic cond_lookup(logic [11:0] line, logic [3:0] pos, logic [15:0] tgt, logic [3:0] bpos);
      @(negedge clk);
      s1_valid = 1; s1_line = line; s1_pos = pos;
      s2_line = line; s2_xfer = 2'd0;
      tk_hit = 1; tk_kind = 2'd0; tk_tgt = tgt; tk_pos = bpos;
      @(negedge clk);
      s1_valid = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 nxt_valid", nxt_valid, 0);
      check("R1 ghr", ghr_o, 0);
      check("R1 alt_addr", alt_addr_q, 0);
      check("R1 alt_hist", alt_hist_q, 0);

      // table-driven selection cases
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         s1_valid = 1; s1_line = 12'h050; s1_pos = 0;
         load_vec(VECS[i], 12'h050);
         check("R12 not yet valid", nxt_valid, 0);
         @(negedge clk);
         s1_valid = 0;
         check("R12 valid after one clock", nxt_valid, 1);
         check($sformatf("R2-set vec%0d addr", i), nxt_addr, VECS[i].ea);
         check($sformatf("R11 vec%0d pos", i), nxt_pos, VECS[i].ep);
         check($sformatf("R11 vec%0d xfer", i), nxt_xfer, VECS[i].ex);
         @(negedge clk);
         check("R12 valid drops", nxt_valid, 0);
      end
      check("R9 ghr after not-taken shifts", ghr_o, 0);

      // R1 weakly not-taken: one taken update flips index 0x23
      train(8'h23, 1);
      cond_lookup(12'h012, 4'd3, 16'h6660, 4'd8);
      check("R1 single update predicts taken", nxt_addr, 16'h6660);
      check("R11 taken cond xfer", nxt_xfer, 0);
      check("R11 cond flags", {nxt_cond, nxt_taken}, 2'b11);
      @(negedge clk);
      check("R9 ghr shifted taken", ghr_o, 8'h01);
      check("R10 alt addr", alt_addr_q, 16'h0129);
      check("R10 alt hist", alt_hist_q, 8'h00);

      // R8 saturation: 3 more taken then 2 not-taken gives 01 (not-taken)
      train(8'h23, 1); train(8'h23, 1); train(8'h23, 1);
      train(8'h23, 0); train(8'h23, 0);
      // index (0x0122 low byte) ^ ghr 0x01 = 0x23
      cond_lookup(12'h012, 4'd2, 16'h6660, 4'd8);
      check("R8 saturating counter", nxt_addr, 16'h0129);
      check("R8 not-taken flag", nxt_taken, 0);
      @(negedge clk);
      check("R9 ghr shifted not-taken", ghr_o, 8'h02);
      check("R10 alt addr is target", alt_addr_q, 16'h6660);

      // R9 redirect has priority over a same-cycle shift
      @(negedge clk);
      s1_valid = 1; s1_line = 12'h050; s1_pos = 0;
      s2_line = 12'h050; s2_xfer = 0; tk_hit = 1; tk_kind = 0; tk_tgt = 16'h3000; tk_pos = 4'd7;
      @(negedge clk);
      s1_valid = 0; rd_valid = 1; rd_hist = 8'h5A;
      @(negedge clk);
      rd_valid = 0;
      check("R9 redirect priority", ghr_o, 8'h5A);
      check("R10 alt hist opposite", alt_hist_q, 8'h05);
      @(negedge clk);
      rd_valid = 1; rd_hist = 8'h00;
      @(negedge clk);
      rd_valid = 0;
      check("R9 redirect load", ghr_o, 8'h00);

      // R7 forwarding of stage-2 position into the stage-1 index
      train(8'h47, 1);
      @(negedge clk);
      s1_valid = 1; s1_line = 12'h030; s1_pos = 0;
      s2_line = 12'h030; s2_xfer = 0; tk_hit = 1; tk_kind = 2'd1; tk_tgt = 16'h0440; tk_pos = 4'd7;
      @(negedge clk);
      s1_valid = 1; s1_line = 12'h044; s1_pos = 4'd0;
      check("R7 first block jump", nxt_addr, 16'h0440);
      @(negedge clk);
      s1_valid = 0;
      s2_line = 12'h044; tk_kind = 2'd0; tk_tgt = 16'h7770; tk_pos = 4'd5;
      #1;
      check("R7 forwarded position index", nxt_addr, 16'h7770);
      @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule